// File: doc/BRIEF.md
# Processor Status Word with Arithmetic Flag Update

This block holds the 16-bit status word of a small 16-bit RISC core. It also contains the logic that turns ALU results into the carry, zero, negative and overflow flags. The ALU supplies:

- its result;
- the carry out of bit 7 and the carry out of bit 15;
- the sign bits of both operands, taken at bit 7 and at bit 15.

A byte/word select tells the block which of these to use. The decoder raises a per-instruction update enable when the instruction is allowed to change the flags.

Software can overwrite the whole word through a write port. Three kinds of event also change the interrupt-enable and power-mode bits by themselves:

- interrupt entry;
- return from interrupt;
- wake events from enabled interrupts.

The register value is available as one word, and each flag and power-mode bit also has its own output.

Top module: `status_word_reg`

## Requirements
- R1: The bit layout of `sr_o` is fixed as follows, and each single-bit output equals its bit of `sr_o`.

  | Bit | Field |
  |-----|-------|
  | 0 | carry |
  | 1 | zero |
  | 2 | negative |
  | 3 | global interrupt enable |
  | 4 | CPU off |
  | 5 | oscillator off |
  | 6 | clock-generator bit 0 |
  | 7 | clock-generator bit 1 |
  | 8 | overflow |

- R2: Bits 15:9 of `sr_o` always read 0, and a software write with ones in those bits leaves them 0.
- R3: On a flag update, negative takes result bit 7 in byte mode (`byte_mode_i`=1) and result bit 15 in word mode.
- R4: On a flag update, zero is 1 exactly when result bits 7:0 (byte mode) or 15:0 (word mode) are all 0.
- R5: On a flag update, carry takes `carry_i[0]` (the carry out of bit 7) in byte mode and `carry_i[1]` (the carry out of bit 15) in word mode.
- R6: On a flag update, overflow is 1 exactly when both operand signs are equal and the result sign differs from them. The operand signs come from index 0 of `a_sign_i`/`b_sign_i` in byte mode and from index 1 in word mode.
- R7: With `flag_upd_i` low and no other event, the register keeps its value one cycle later.
- R8: A software write loads bits 8:0 from `sw_wdata_i` one cycle later.
- R9: Interrupt entry clears the interrupt-enable bit and interrupt return sets it. When both occur in the same cycle, entry wins.
- R10: A wake event clears CPU-off. An external wake event clears both CPU-off and oscillator-off.
- R11: In the same cycle, an automatic event overrides a software write on the bits that event touches, and a software write overrides the arithmetic flag update.
- R12: Active-low asynchronous reset clears the whole register to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_mode_i | input | 1 | 1 = byte operation, 0 = word operation |
| alu_res_i | input | 16 | ALU result |
| carry_i | input | 2 | [0] carry out of bit 7, [1] carry out of bit 15 |
| a_sign_i | input | 2 | First operand sign: [0] bit 7, [1] bit 15 |
| b_sign_i | input | 2 | Second operand sign: [0] bit 7, [1] bit 15 |
| flag_upd_i | input | 1 | Update the arithmetic flags this cycle |
| sw_we_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 16 | Software write data |
| irq_entry_i | input | 1 | Interrupt entry strobe |
| irq_ret_i | input | 1 | Return-from-interrupt strobe |
| wake_i | input | 1 | Enabled interrupt wake event |
| wake_ext_i | input | 1 | Enabled external interrupt wake event |
| sr_o | output | 16 | Full status word |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| gie_o | output | 1 | Global interrupt enable |
| cpu_off_o | output | 1 | CPU-off bit |
| osc_off_o | output | 1 | Oscillator-off bit |
| scg_o | output | 2 | Clock-generator bits (bit 6 = [0], bit 7 = [1]) |
| ovf_o | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default width of 16. That places the byte/word split between bit 7 and bit 15, so one result can give different flag values in the two modes, and the vectors use exactly such results. The upper implemented bit is 8 and the unimplemented range is 15:9, which gives all-ones writes unimplemented bits that they can try to set. Same-cycle collisions are driven on purpose to show the stated priority order: entry against return, software write against automatic event, and software write against arithmetic update.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IMPL_W = 9;

  localparam int unsigned B_C      = 0;
  localparam int unsigned B_Z      = 1;
  localparam int unsigned B_N      = 2;
  localparam int unsigned B_GIE    = 3;
  localparam int unsigned B_CPUOFF = 4;
  localparam int unsigned B_OSCOFF = 5;
  localparam int unsigned B_SCG0   = 6;
  localparam int unsigned B_SCG1   = 7;
  localparam int unsigned B_V      = 8;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/sr_flag_calc.sv
module sr_flag_calc
  import sr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              byte_mode_i,
  input  logic [DATA_W-1:0] res_i,
  input  logic [1:0]        carry_i,
  input  logic [1:0]        a_sign_i,
  input  logic [1:0]        b_sign_i,
  output arith_flags_t      flags_o
);
  localparam int unsigned HI_W = DATA_W - BYTE_W;

  logic lo_zero, hi_zero, res_msb, sa, sb;
  logic wsel;

  assign wsel    = ~byte_mode_i;
  assign lo_zero = ~|res_i[BYTE_W-1:0];

  // upper-part zero detect; a byte-wide datapath has no upper part
  generate
    if (HI_W > 0) begin : g_hi
      assign hi_zero = ~|res_i[DATA_W-1:BYTE_W];
    end else begin : g_no_hi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign res_msb = byte_mode_i ? res_i[BYTE_W-1] : res_i[DATA_W-1];
  assign sa      = a_sign_i[wsel];
  assign sb      = b_sign_i[wsel];

  always_comb begin
    flags_o.c = carry_i[wsel];
    flags_o.z = byte_mode_i ? lo_zero : (lo_zero & hi_zero);
    flags_o.n = res_msb;
    flags_o.v = (sa == sb) && (res_msb != sa);
  end
endmodule

// File: rtl/sr_next.sv
module sr_next
  import sr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] cur_i,
  input  arith_flags_t      flags_i,
  input  logic              upd_i,
  input  logic              sw_we_i,
  input  logic [DATA_W-1:0] sw_wdata_i,
  input  logic              irq_entry_i,
  input  logic              irq_ret_i,
  input  logic              wake_i,
  input  logic              wake_ext_i,
  output logic [DATA_W-1:0] nxt_o
);
  localparam logic [DATA_W-1:0] IMPL_MASK =
    {{(DATA_W-IMPL_W){1'b0}}, {IMPL_W{1'b1}}};

  logic [DATA_W-1:0] n;

  // order = priority: arith < software < automatic events
  always_comb begin
    n = cur_i;
    if (upd_i) begin
      n[B_C] = flags_i.c;
      n[B_Z] = flags_i.z;
      n[B_N] = flags_i.n;
      n[B_V] = flags_i.v;
    end
    if (sw_we_i) n = sw_wdata_i;
    if (irq_ret_i)   n[B_GIE] = 1'b1;
    if (irq_entry_i) n[B_GIE] = 1'b0;
    if (wake_i || wake_ext_i) n[B_CPUOFF] = 1'b0;
    if (wake_ext_i) n[B_OSCOFF] = 1'b0;
    nxt_o = n & IMPL_MASK;
  end
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
  import sr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_mode_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic [1:0]        carry_i,
  input  logic [1:0]        a_sign_i,
  input  logic [1:0]        b_sign_i,
  input  logic              flag_upd_i,
  input  logic              sw_we_i,
  input  logic [DATA_W-1:0] sw_wdata_i,
  input  logic              irq_entry_i,
  input  logic              irq_ret_i,
  input  logic              wake_i,
  input  logic              wake_ext_i,
  output logic [DATA_W-1:0] sr_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              gie_o,
  output logic              cpu_off_o,
  output logic              osc_off_o,
  output logic [1:0]        scg_o,
  output logic              ovf_o
);
  arith_flags_t      flags;
  logic [DATA_W-1:0] sr_q, sr_d;

  sr_flag_calc #(.DATA_W(DATA_W)) i_calc (
    .byte_mode_i (byte_mode_i),
    .res_i       (alu_res_i),
    .carry_i     (carry_i),
    .a_sign_i    (a_sign_i),
    .b_sign_i    (b_sign_i),
    .flags_o     (flags)
  );

  sr_next #(.DATA_W(DATA_W)) i_next (
    .cur_i       (sr_q),
    .flags_i     (flags),
    .upd_i       (flag_upd_i),
    .sw_we_i     (sw_we_i),
    .sw_wdata_i  (sw_wdata_i),
    .irq_entry_i (irq_entry_i),
    .irq_ret_i   (irq_ret_i),
    .wake_i      (wake_i),
    .wake_ext_i  (wake_ext_i),
    .nxt_o       (sr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign sr_o      = sr_q;
  assign carry_o   = sr_q[B_C];
  assign zero_o    = sr_q[B_Z];
  assign neg_o     = sr_q[B_N];
  assign gie_o     = sr_q[B_GIE];
  assign cpu_off_o = sr_q[B_CPUOFF];
  assign osc_off_o = sr_q[B_OSCOFF];
  assign scg_o     = {sr_q[B_SCG1], sr_q[B_SCG0]};
  assign ovf_o     = sr_q[B_V];
endmodule

// File: rtl/sr_checker.sv
module sr_checker
  import sr_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_mode_i,
  input logic [DATA_W-1:0] alu_res_i,
  input logic              flag_upd_i,
  input logic              sw_we_i,
  input logic              irq_entry_i,
  input logic              irq_ret_i,
  input logic              wake_i,
  input logic              wake_ext_i,
  input logic [DATA_W-1:0] sr_o,
  input logic              neg_o,
  input logic              gie_o,
  input logic              cpu_off_o,
  input logic              osc_off_o
);
  logic quiet;
  assign quiet = !flag_upd_i && !sw_we_i && !irq_entry_i && !irq_ret_i
                 && !wake_i && !wake_ext_i;

  p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_o[DATA_W-1:IMPL_W] == '0);

  p_neg_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_upd_i && !sw_we_i) |=>
      neg_o == $past(byte_mode_i ? alu_res_i[BYTE_W-1] : alu_res_i[DATA_W-1]));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> $stable(sr_o));

  p_entry_clears_gie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_entry_i |=> !gie_o);

  p_ret_sets_gie_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ret_i && !irq_entry_i) |=> gie_o);

  p_wake_cpu_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i || wake_ext_i) |=> !cpu_off_o);

  p_wake_osc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_ext_i |=> !osc_off_o);
endmodule

bind status_word_reg sr_checker #(.DATA_W(DATA_W)) i_sr_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .byte_mode_i (byte_mode_i),
  .alu_res_i   (alu_res_i),
  .flag_upd_i  (flag_upd_i),
  .sw_we_i     (sw_we_i),
  .irq_entry_i (irq_entry_i),
  .irq_ret_i   (irq_ret_i),
  .wake_i      (wake_i),
  .wake_ext_i  (wake_ext_i),
  .sr_o        (sr_o),
  .neg_o       (neg_o),
  .gie_o       (gie_o),
  .cpu_off_o   (cpu_off_o),
  .osc_off_o   (osc_off_o)
);

// File: tb/test_status_word_reg.sv
`timescale 1ns/1ps
module test_status_word_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        byte_mode_i = 1'b0;
  logic [15:0] alu_res_i = '0;
  logic [1:0]  carry_i = '0, a_sign_i = '0, b_sign_i = '0;
  logic        flag_upd_i = 1'b0, sw_we_i = 1'b0;
  logic [15:0] sw_wdata_i = '0;
  logic        irq_entry_i = 1'b0, irq_ret_i = 1'b0, wake_i = 1'b0, wake_ext_i = 1'b0;
  logic [15:0] sr_o;
  logic        carry_o, zero_o, neg_o, gie_o, cpu_off_o, osc_off_o, ovf_o;
  logic [1:0]  scg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  status_word_reg i_status_word_reg (.*);

  // {byte, result, carry, a_sign, b_sign, expected {V,N,Z,C}}
  localparam logic [26:0] VEC [0:7] = '{
    {1'b0, 16'h0000, 2'b00, 2'b00, 2'b00, 4'b0010},
    {1'b0, 16'h8000, 2'b00, 2'b00, 2'b00, 4'b1100},
    {1'b0, 16'h0000, 2'b10, 2'b10, 2'b10, 4'b1011},
    {1'b1, 16'h1200, 2'b00, 2'b00, 2'b00, 4'b0010},
    {1'b1, 16'h0080, 2'b00, 2'b00, 2'b00, 4'b1100},
    {1'b1, 16'h8001, 2'b10, 2'b10, 2'b10, 4'b0000},
    {1'b0, 16'h8001, 2'b01, 2'b10, 2'b00, 4'b0100},
    {1'b1, 16'h00FF, 2'b01, 2'b01, 2'b01, 4'b0101}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    flag_upd_i = 0; sw_we_i = 0; irq_entry_i = 0; irq_ret_i = 0;
    wake_i = 0; wake_ext_i = 0;
  endtask

  task automatic sw_write(input logic [15:0] d);
    sw_we_i = 1; sw_wdata_i = d;
    step();
  endtask

  initial begin
    logic [3:0] exp;
    repeat (2) @(negedge clk_i);
    check("R12 reset value", sr_o, 16'h0000);
    rst_ni = 1;
    @(negedge clk_i);

    for (int i = 0; i < 8; i++) begin
      {byte_mode_i, alu_res_i, carry_i, a_sign_i, b_sign_i, exp} = VEC[i];
      flag_upd_i = 1;
      step();
      check($sformatf("R3/R4/R5/R6 vector %0d", i),
            {12'h000, sr_o[8], sr_o[2:0]}, {12'h000, exp});
    end

    sw_write(16'hFFFF);
    check("R2/R8 write all ones", sr_o, 16'h01FF);

    byte_mode_i = 0; alu_res_i = 16'h0000; carry_i = 0; a_sign_i = 0; b_sign_i = 0;
    step();
    check("R7 no update holds", sr_o, 16'h01FF);

    irq_entry_i = 1; step();
    check("R9 entry clears enable", sr_o, 16'h01F7);
    irq_ret_i = 1; step();
    check("R9 return sets enable", sr_o, 16'h01FF);
    irq_entry_i = 1; irq_ret_i = 1; step();
    check("R9 entry beats return", sr_o, 16'h01F7);

    wake_i = 1; step();
    check("R10 wake clears cpu off", sr_o, 16'h01E7);
    sw_write(16'h01FF);
    wake_ext_i = 1; step();
    check("R10 external wake clears both", sr_o, 16'h01CF);

    sw_we_i = 1; sw_wdata_i = 16'hFFFF; irq_entry_i = 1; step();
    check("R11 entry beats write", sr_o, 16'h01F7);
    sw_we_i = 1; sw_wdata_i = 16'h0000; flag_upd_i = 1; alu_res_i = 16'h0000;
    step();
    check("R11 write beats arith", sr_o, 16'h0000);

    sw_write(16'h0155);
    check("R1 word 155", sr_o, 16'h0155);
    check("R1 single outputs",
          {7'h00, ovf_o, scg_o, osc_off_o, cpu_off_o, gie_o, neg_o, zero_o, carry_o},
          16'h0155);
    sw_write(16'hFEAA);
    check("R1/R2 word AA", sr_o, 16'h00AA);
    check("R1 single outputs AA",
          {7'h00, ovf_o, scg_o, osc_off_o, cpu_off_o, gie_o, neg_o, zero_o, carry_o},
          16'h00AA);

    #1 rst_ni = 0;
    #1 check("R12 async reset", sr_o, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule